// File: doc/BRIEF.md
# Parallel-Lane Internet Checksum Accumulator

This block produces the 16-bit ones'-complement checksum used by internet protocols over a packet that arrives as a stream of wide beats. Each beat holds several 16-bit words side by side. The block adds the whole beat into a wide accumulator in a single cycle with an end-around carry, so it takes in one beat of words per clock rather than one word. The per-lane sums stay unreduced until the packet is complete.

A start pulse opens a packet and clears the accumulator. Beats are then presented with a byte-keep mask. A finish pulse reduces the accumulator: the lane fields are added together, the carries above bit 15 are wrapped back into the low bits, and the result is inverted. The checksum is registered and stays on the output until the next start. The result matches, bit for bit, a word-serial reference that adds the 16-bit words into a 32-bit sum and then folds it.

Top module: `csum_accum`

## Requirements
- R1: While reset is active, and after it is released with no finish, `sum_valid_o` is 0.
- R2: With all bytes kept, the result equals the complement of the ones'-complement sum of every 16-bit word in every accepted beat. Lane k is bits [16k+15:16k].
- R3: A carry out of the top bit of the accumulator is added back into bit 0, so long runs of 0xFFFF words give the same result as the word-serial reference.
- R4: A packet whose words are all zero, or a packet with no beats, yields 0xFFFF.
- R5: Keep bit 2k+1 enables the high byte of lane k (bits 16k+15:16k+8) and keep bit 2k enables its low byte (bits 16k+7:16k). A disabled byte counts as zero. An odd trailing byte is therefore padded with a zero low byte.
- R6: A start pulse discards all earlier accumulation. A beat presented in the same cycle as start is taken as the first beat of the new packet.
- R7: `sum_valid_o` rises in the cycle after finish, and never without finish. A beat presented together with finish is included in the result.
- R8: Once the result is valid, it and `sum_valid_o` hold steady until a start. Beats and finish pulses in that interval are ignored.
- R9: A start without finish makes `sum_valid_o` 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a packet and clears the accumulator |
| beat_valid_i | input | 1 | A beat is present on `beat_data_i` |
| beat_data_i | input | 64 | Four 16-bit words; lane k in bits [16k+15:16k] |
| beat_keep_i | input | 8 | Per-byte enable; bit 2k+1 is the high byte and bit 2k the low byte of lane k |
| finish_i | input | 1 | Ends the packet and requests the checksum |
| sum_o | output | 16 | Complemented, folded checksum |
| sum_valid_o | output | 1 | `sum_o` holds the checksum of the last finished packet |

## Verification
The bench builds the block with its default of four 16-bit lanes. This configuration makes the full byte-keep space small enough to sweep: all 256 masks are applied to one fixed beat. The bench also runs about sixty generated packets of up to forty beats with random trailing masks. Runs of all-ones words drive the wide end-around carry, and the fold-carry paths are covered as well. The start-with-beat, finish-with-beat and ignore-while-holding corners are each reached directly at these parameter values.

// File: rtl/csum_pkg.sv
package csum_pkg;
  localparam int WORD_W = 16;
  localparam int RED_W  = 32;

  // Reduce a 32-bit ones'-complement partial sum to 16 bits, non-inverted.
  function automatic logic [WORD_W-1:0] ones_fold(input logic [RED_W-1:0] v);
    logic [WORD_W:0] t;
    t = {1'b0, v[WORD_W-1:0]} + {1'b0, v[RED_W-1:WORD_W]};
    return t[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, t[WORD_W]};
  endfunction
endpackage

// File: rtl/csum_byte_mask.sv
module csum_byte_mask #(
  parameter int BYTES = 8
) (
  input  logic [BYTES*8-1:0] data_i,
  input  logic [BYTES-1:0]   keep_i,
  output logic [BYTES*8-1:0] data_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign data_o[b*8 +: 8] = keep_i[b] ? data_i[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/csum_eac_add.sv
module csum_eac_add #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W:0] raw;
  assign raw     = {1'b0, a_i} + {1'b0, b_i};
  assign carry_o = raw[W];
  // Wrapping the carry back cannot overflow again: a carry leaves raw[W-1:0] <= 2^W-2.
  assign sum_o   = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
endmodule

// File: rtl/csum_lane_fold.sv
module csum_lane_fold #(
  parameter int LANES = 4
) (
  input  logic [LANES*csum_pkg::WORD_W-1:0] acc_i,
  output logic [csum_pkg::WORD_W-1:0]       folded_o
);
  import csum_pkg::*;
  logic [RED_W-1:0] total;
  always_comb begin
    total = '0;
    for (int i = 0; i < LANES; i++) begin
      total = total + RED_W'(acc_i[i*WORD_W +: WORD_W]);
    end
    folded_o = ones_fold(total);
  end
endmodule

// File: rtl/csum_accum.sv
module csum_accum #(
  parameter int LANES = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start_i,
  input  logic                             beat_valid_i,
  input  logic [LANES*csum_pkg::WORD_W-1:0] beat_data_i,
  input  logic [LANES*2-1:0]               beat_keep_i,
  input  logic                             finish_i,
  output logic [csum_pkg::WORD_W-1:0]      sum_o,
  output logic                             sum_valid_o
);
  import csum_pkg::*;
  localparam int ACC_W = LANES * WORD_W;
  localparam int BYTES = LANES * 2;

  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  acc_base;
  logic [ACC_W-1:0]  masked_beat;
  logic [ACC_W-1:0]  addend;
  logic [ACC_W-1:0]  acc_next;
  logic              wrap_carry;
  logic              open_pkt;
  logic              take_beat;
  logic              finish_fire;
  logic [WORD_W-1:0] folded;
  logic [WORD_W-1:0] sum_q;
  logic              valid_q;

  // Packet accepts input when no result is held, or when a start reopens it.
  assign open_pkt    = start_i || !valid_q;
  assign take_beat   = beat_valid_i && open_pkt;
  assign finish_fire = finish_i && open_pkt;
  assign acc_base    = start_i ? '0 : acc_q;
  assign addend      = take_beat ? masked_beat : '0;

  csum_byte_mask #(.BYTES(BYTES)) u_mask (
    .data_i (beat_data_i),
    .keep_i (beat_keep_i),
    .data_o (masked_beat)
  );

  csum_eac_add #(.W(ACC_W)) u_add (
    .a_i     (acc_base),
    .b_i     (addend),
    .sum_o   (acc_next),
    .carry_o (wrap_carry)
  );

  csum_lane_fold #(.LANES(LANES)) u_fold (
    .acc_i    (acc_next),
    .folded_o (folded)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      sum_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (open_pkt) acc_q <= acc_next;
      if (finish_fire) begin
        sum_q   <= ~folded;
        valid_q <= 1'b1;
      end else if (start_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign sum_o       = sum_q;
  assign sum_valid_o = valid_q;
endmodule

// File: rtl/csum_accum_chk.sv
module csum_accum_chk #(
  parameter int ACC_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             finish_i,
  input logic             beat_valid_i,
  input logic             open_pkt,
  input logic             wrap_carry,
  input logic [ACC_W-1:0] acc_q,
  input logic [15:0]      sum_o,
  input logic             sum_valid_o
);
  // R6
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !beat_valid_i) |=> (acc_q == '0));
  // R7
  valid_needs_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sum_valid_o) |-> $past(finish_i));
  // R7
  finish_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_i && open_pkt) |=> sum_valid_o);
  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_valid_o && !start_i) |=> (sum_valid_o && $stable(sum_o) && $stable(acc_q)));
  // R9
  start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !finish_i) |=> !sum_valid_o);
  // R3
  wrap_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_carry && open_pkt) |=> (acc_q != '0));
endmodule

bind csum_accum csum_accum_chk #(.ACC_W(ACC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .finish_i     (finish_i),
  .beat_valid_i (beat_valid_i),
  .open_pkt     (open_pkt),
  .wrap_carry   (wrap_carry),
  .acc_q        (acc_q),
  .sum_o        (sum_o),
  .sum_valid_o  (sum_valid_o)
);

// File: tb/csum_accum_tb.sv
module csum_accum_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        beat_valid_i = 1'b0;
  logic [63:0] beat_data_i = '0;
  logic [7:0]  beat_keep_i = '0;
  logic        finish_i = 1'b0;
  logic [15:0] sum_o;
  logic        sum_valid_o;

  int          n_checks = 0;
  int          n_fail = 0;
  longint      cycles = 0;
  logic [31:0] ref_acc = '0;
  logic [63:0] seed = 64'h1234_5678_9abc_def1;

  csum_accum u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .beat_valid_i(beat_valid_i),
    .beat_data_i(beat_data_i), .beat_keep_i(beat_keep_i), .finish_i(finish_i),
    .sum_o(sum_o), .sum_valid_o(sum_valid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      summary();
    end
  end

  function automatic logic [63:0] next_rand();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed ^ (seed >> 29);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Word-serial reference: 32-bit sum of words, then fold while carries remain.
  function automatic logic [15:0] ref_result();
    logic [31:0] s = ref_acc;
    while (s[31:16] != 0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    return ~s[15:0];
  endfunction

  task automatic ref_beat(input logic [63:0] d, input logic [7:0] k);
    for (int w = 0; w < 4; w++) begin
      logic [7:0] hi = k[2*w+1] ? d[16*w+8 +: 8] : 8'h00;
      logic [7:0] lo = k[2*w]   ? d[16*w +: 8]   : 8'h00;
      ref_acc = ref_acc + {16'h0, hi, lo};
    end
  endtask

  // All tasks are entered right after a falling edge and leave right after one.
  task automatic do_start(input bit with_beat, input logic [63:0] d, input logic [7:0] k);
    start_i = 1'b1;
    beat_valid_i = with_beat;
    beat_data_i = d;
    beat_keep_i = k;
    ref_acc = '0;
    if (with_beat) ref_beat(d, k);
    @(negedge clk);
    start_i = 1'b0;
    beat_valid_i = 1'b0;
  endtask

  task automatic do_beat(input logic [63:0] d, input logic [7:0] k);
    beat_valid_i = 1'b1;
    beat_data_i = d;
    beat_keep_i = k;
    ref_beat(d, k);
    @(negedge clk);
    beat_valid_i = 1'b0;
  endtask

  task automatic do_finish(input string req, input bit with_beat, input logic [63:0] d, input logic [7:0] k);
    logic [15:0] exp;
    finish_i = 1'b1;
    beat_valid_i = with_beat;
    beat_data_i = d;
    beat_keep_i = k;
    if (with_beat) ref_beat(d, k);
    exp = ref_result();
    @(negedge clk);
    finish_i = 1'b0;
    beat_valid_i = 1'b0;
    check(sum_valid_o == 1'b1, {req, " valid"}, 32'(sum_valid_o), 32'd1);
    check(sum_o == exp, req, 32'(sum_o), 32'(exp));
  endtask

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sum_valid_o == 1'b0, "R1 in reset", 32'(sum_valid_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sum_valid_o == 1'b0, "R1 after reset", 32'(sum_valid_o), 32'd0);

    // R4: empty packet and all-zero packet
    do_start(1'b0, '0, '0);
    do_finish("R4 empty", 1'b0, '0, '0);
    check(sum_o == 16'hFFFF, "R4 empty value", 32'(sum_o), 32'hFFFF);
    do_start(1'b0, '0, '0);
    do_beat('0, 8'hFF);
    do_beat('0, 8'hFF);
    do_finish("R4 zeros", 1'b0, '0, '0);
    check(sum_o == 16'hFFFF, "R4 zeros value", 32'(sum_o), 32'hFFFF);

    // R9: start drops the held result
    do_start(1'b0, '0, '0);
    check(sum_valid_o == 1'b0, "R9 start drop", 32'(sum_valid_o), 32'd0);

    // R3: long run of all-ones words forces the wide end-around carry
    for (int n = 1; n <= 24; n += 3) begin
      do_start(1'b0, '0, '0);
      for (int b = 0; b < n; b++) do_beat({64{1'b1}}, 8'hFF);
      do_beat(64'h0000_0000_0000_0001, 8'hFF);
      do_finish("R3 all ones", 1'b0, '0, '0);
    end

    // R2: generated full-beat packets
    for (int p = 0; p < 30; p++) begin
      int nb = 1 + int'(next_rand() % 40);
      do_start(1'b0, '0, '0);
      for (int b = 0; b < nb; b++) do_beat(next_rand(), 8'hFF);
      check(sum_valid_o == 1'b0, "R7 not before finish", 32'(sum_valid_o), 32'd0);
      do_finish("R2 random packet", 1'b0, '0, '0);
    end

    // R5: random trailing masks
    for (int p = 0; p < 30; p++) begin
      int nb = int'(next_rand() % 20);
      do_start(1'b0, '0, '0);
      for (int b = 0; b < nb; b++) do_beat(next_rand(), 8'hFF);
      do_beat(next_rand(), 8'(next_rand()));
      do_finish("R5 partial last beat", 1'b0, '0, '0);
    end

    // R5: full sweep of keep masks on one beat
    for (int k = 0; k < 256; k++) begin
      do_start(1'b0, '0, '0);
      do_beat(64'hF1E2_D3C4_B5A6_9788, 8'(k));
      do_finish("R5 keep sweep", 1'b0, '0, '0);
    end

    // R6: start with a beat discards stale data and keeps the new beat
    do_start(1'b0, '0, '0);
    do_beat(64'h1111_2222_3333_4444, 8'hFF);
    do_start(1'b1, 64'h0102_0304_0506_0708, 8'hFF);
    do_beat(64'hA0B0_C0D0_E0F0_0A0B, 8'hFF);
    do_finish("R6 start with beat", 1'b0, '0, '0);

    // R7: beat together with finish is counted
    do_start(1'b0, '0, '0);
    do_beat(64'h8000_8000_8000_8000, 8'hFF);
    do_finish("R7 finish with beat", 1'b1, 64'hFFFE_0001_7FFF_0002, 8'hFF);

    // R8: held result ignores beats and further finishes
    held = sum_o;
    beat_valid_i = 1'b1;
    beat_data_i = 64'hDEAD_BEEF_0BAD_F00D;
    beat_keep_i = 8'hFF;
    @(negedge clk);
    beat_valid_i = 1'b0;
    finish_i = 1'b1;
    @(negedge clk);
    finish_i = 1'b0;
    @(negedge clk);
    check(sum_valid_o == 1'b1, "R8 still valid", 32'(sum_valid_o), 32'd1);
    check(sum_o == held, "R8 held value", 32'(sum_o), 32'(held));

    // R9 again after a long hold
    do_start(1'b0, '0, '0);
    check(sum_valid_o == 1'b0, "R9 start drop after hold", 32'(sum_valid_o), 32'd0);

    summary();
  end
endmodule